// File: doc/BRIEF.md
# USB Line-State Monitor with Bus-Reset Detection

This block sits on the link side of a UTMI+ transceiver interface and watches the two-bit line-state code that the transceiver reports. The code can arrive unaligned to the link clock, for example while the transceiver is suspended or resuming. The block therefore passes the code through a two-flop synchronizer. It then decodes the code into one of the four bus conditions SE0, J, K or SE1, using the interpretation that the selected bus mode calls for. A new condition is accepted only after it has been seen in two consecutive synchronized samples, so short glitches never reach the link logic.

The accepted condition drives three things: the decoded output, a one-cycle change strobe, and a saturating dwell counter that reports how many clocks the condition has lasted. In high-speed device mode, squelch shows up as SE0 and any bus activity is forced to J. Idle is therefore measured purely as time spent in SE0. An idle timer emits a single bus-reset pulse once SE0 has lasted the programmed interval, which is 180000 clocks (3 ms at 60 MHz) by default. It then waits for the line to leave SE0 before it can fire again.

Two small state machines do the work. The filter machine has the states STEADY and PEND. From STEADY it moves to PEND when a sample differs from the accepted condition. From PEND it returns to STEADY when the candidate repeats, and the candidate is then accepted. It also returns to STEADY when the sample falls back to the accepted condition. From PEND it stays in PEND with a fresh candidate when a third value arrives. The idle machine has the states OFF, COUNT and FIRED. It moves from OFF to COUNT when SE0 is seen in high-speed device mode. From COUNT it moves to FIRED when the limit is reached, and the pulse is emitted on that transition. From COUNT or FIRED it returns to OFF as soon as the line leaves SE0 or the mode changes.

Top module: `usb_line_monitor`

## Requirements
- R1: A raw line code held steady on `line_raw` appears on `line_state` after the 4th rising clock edge that samples it: two edges of synchronization and two edges of stability confirmation. Before that edge the previous value remains on `line_state`.
- R2: In modes 00 (high-speed device), 01 (full speed) and 11 (treated as full speed), raw code 00 decodes to SE0, 01 to J, 10 to K and 11 to SE1. `line_state` carries these as the codes 00, 01, 10 and 11.
- R3: In mode 10 (low-speed host), J and K are swapped. Raw 01 is reported as K (`line_state` = 10) and raw 10 as J (`line_state` = 01), while SE0 and SE1 are unchanged.
- R4: A raw value present for only one clock is ignored: `line_state` keeps its value and `line_change` stays low. A value present for two clocks is accepted.
- R5: `line_change` is high for exactly one cycle, namely the first cycle in which `line_state` shows a new value. `line_state` never changes without it.
- R6: `dwell` reads 0 in the cycle of a change and rises by one per clock after it. It saturates at 2^DWELL_W-1.
- R7: In mode 00, once `line_state` has shown SE0 for IDLE_CLKS consecutive cycles, `bus_reset` is high for exactly one cycle, IDLE_CLKS cycles after SE0 first appeared.
- R8: Only one `bus_reset` pulse is produced per continuous SE0 period, however long it lasts. After the line leaves SE0, a new SE0 period produces a new pulse.
- R9: `bus_reset` never fires in modes other than 00. An SE0 period that ends before IDLE_CLKS cycles fires nothing, and the next SE0 period is timed from its own start.
- R10: While `rst` is high and on leaving reset, `line_state` is SE0 (00), `line_change` is 0, `bus_reset` is 0 and `dwell` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_mode | input | 2 | 00 high-speed device, 01 full speed, 10 low-speed host, 11 full speed |
| line_raw | input | 2 | Raw line-state code from the transceiver, bit 0 following D+, bit 1 following D- |
| line_state | output | 2 | Accepted decoded condition: 00 SE0, 01 J, 10 K, 11 SE1 |
| line_change | output | 1 | One-cycle strobe when `line_state` takes a new value |
| bus_reset | output | 1 | One-cycle pulse when high-speed idle reaches IDLE_CLKS |
| dwell | output | DWELL_W | Saturating clock count since the last change |

## Verification
Every ordered pair of distinct raw codes is applied as a transition in each of the four mode codes. This sweep separates the plain decoding from the low-speed swap and pins down the four-edge latency, the one-cycle strobe and the dwell restart for each pair. One-clock and two-clock pulses on the raw code distinguish glitch rejection from acceptance, and a long steady hold exposes the dwell saturation. The idle timer is exercised in four ways: with a long SE0 in high-speed device mode, with SE0 released and reapplied, with an SE0 cut short before the limit, and with long SE0 periods in the full- and low-speed modes. Together these separate the correct firing cycle from single-pulse behaviour, re-arming, abort and mode gating.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_e;

    typedef enum logic [1:0] {
        MODE_HS_DEV  = 2'b00,
        MODE_FS      = 2'b01,
        MODE_LS_HOST = 2'b10,
        MODE_RSVD    = 2'b11
    } bus_mode_e;

    typedef enum logic {
        FLT_STEADY,
        FLT_PEND
    } flt_state_e;

    typedef enum logic [1:0] {
        IDL_OFF,
        IDL_COUNT,
        IDL_FIRED
    } idl_state_e;

    // Low-speed host swaps the J and K meanings of codes 01 and 10.
    function automatic line_e decode_line(input logic [1:0] code, input bus_mode_e mode);
        logic [1:0] v;
        v = code;
        if (mode == MODE_LS_HOST && (code == 2'b01 || code == 2'b10)) begin
            v = ~code;
        end
        return line_e'(v);
    endfunction

endpackage

// File: rtl/lsm_sync.sv
module lsm_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/lsm_filter.sv
module lsm_filter
    import lsm_pkg::*;
#(
    parameter int DWELL_W = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  line_e              sample,
    output line_e              state_o,
    output logic               change_o,
    output logic [DWELL_W-1:0] dwell_o
);

    localparam logic [DWELL_W-1:0] DWELL_MAX = {DWELL_W{1'b1}};

    flt_state_e         fsm_q, fsm_nx;
    line_e              acc_q, acc_nx;
    line_e              cand_q, cand_nx;
    logic               chg_q, chg_nx;
    logic [DWELL_W-1:0] dwell_q, dwell_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q   <= FLT_STEADY;
            acc_q   <= LS_SE0;
            cand_q  <= LS_SE0;
            chg_q   <= 1'b0;
            dwell_q <= '0;
        end else begin
            fsm_q   <= fsm_nx;
            acc_q   <= acc_nx;
            cand_q  <= cand_nx;
            chg_q   <= chg_nx;
            dwell_q <= dwell_nx;
        end
    end

    always_comb begin
        fsm_nx  = fsm_q;
        acc_nx  = acc_q;
        cand_nx = cand_q;
        chg_nx  = 1'b0;
        unique case (fsm_q)
            FLT_STEADY: begin
                if (sample != acc_q) begin
                    fsm_nx  = FLT_PEND;
                    cand_nx = sample;
                end
            end
            FLT_PEND: begin
                if (sample == cand_q) begin
                    acc_nx = cand_q;
                    chg_nx = 1'b1;
                    fsm_nx = FLT_STEADY;
                end else if (sample == acc_q) begin
                    fsm_nx = FLT_STEADY;
                end else begin
                    cand_nx = sample;
                end
            end
        endcase
        if (chg_nx) dwell_nx = '0;
        else if (dwell_q == DWELL_MAX) dwell_nx = dwell_q;
        else dwell_nx = dwell_q + 1'b1;
    end

    assign state_o  = acc_q;
    assign change_o = chg_q;
    assign dwell_o  = dwell_q;

endmodule

// File: rtl/lsm_idle_timer.sv
module lsm_idle_timer
    import lsm_pkg::*;
#(
    parameter int IDLE_CLKS = 180000
) (
    input  logic      clk,
    input  logic      rst,
    input  line_e     line_i,
    input  bus_mode_e mode_i,
    output logic      reset_o
);

    localparam int CNT_W = $clog2(IDLE_CLKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_CLKS - 1);

    idl_state_e       fsm_q, fsm_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic             pulse_q, pulse_nx;
    logic             idle;

    assign idle = (line_i == LS_SE0) && (mode_i == MODE_HS_DEV);

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q   <= IDL_OFF;
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            fsm_q   <= fsm_nx;
            cnt_q   <= cnt_nx;
            pulse_q <= pulse_nx;
        end
    end

    always_comb begin
        fsm_nx   = fsm_q;
        cnt_nx   = cnt_q;
        pulse_nx = 1'b0;
        unique case (fsm_q)
            IDL_OFF: begin
                if (idle) begin
                    fsm_nx = IDL_COUNT;
                    cnt_nx = CNT_W'(1);
                end
            end
            IDL_COUNT: begin
                if (!idle) begin
                    fsm_nx = IDL_OFF;
                    cnt_nx = '0;
                end else if (cnt_q == LAST) begin
                    fsm_nx   = IDL_FIRED;
                    pulse_nx = 1'b1;
                end else begin
                    cnt_nx = cnt_q + 1'b1;
                end
            end
            IDL_FIRED: begin
                if (!idle) begin
                    fsm_nx = IDL_OFF;
                    cnt_nx = '0;
                end
            end
            default: begin
                fsm_nx = IDL_OFF;
                cnt_nx = '0;
            end
        endcase
    end

    assign reset_o = pulse_q;

endmodule

// File: rtl/usb_line_monitor.sv
module usb_line_monitor
    import lsm_pkg::*;
#(
    parameter int IDLE_CLKS   = 180000,
    parameter int DWELL_W     = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         bus_mode,
    input  logic [1:0]         line_raw,
    output logic [1:0]         line_state,
    output logic               line_change,
    output logic               bus_reset,
    output logic [DWELL_W-1:0] dwell
);

    logic [1:0] raw_sync;
    line_e      decoded;
    line_e      accepted;
    bus_mode_e  mode;

    assign mode = bus_mode_e'(bus_mode);

    lsm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (line_raw),
        .q   (raw_sync)
    );

    assign decoded = decode_line(raw_sync, mode);

    lsm_filter #(.DWELL_W(DWELL_W)) u_filter (
        .clk      (clk),
        .rst      (rst),
        .sample   (decoded),
        .state_o  (accepted),
        .change_o (line_change),
        .dwell_o  (dwell)
    );

    lsm_idle_timer #(.IDLE_CLKS(IDLE_CLKS)) u_idle (
        .clk     (clk),
        .rst     (rst),
        .line_i  (accepted),
        .mode_i  (mode),
        .reset_o (bus_reset)
    );

    assign line_state = accepted;

endmodule

// File: rtl/lsm_checker.sv
module lsm_checker #(
    parameter int DWELL_W = 20
) (
    input logic               clk,
    input logic               rst,
    input logic [1:0]         bus_mode,
    input logic [1:0]         line_state,
    input logic               line_change,
    input logic               bus_reset,
    input logic [DWELL_W-1:0] dwell
);

    localparam logic [DWELL_W-1:0] DMAX = {DWELL_W{1'b1}};

    AST_CHANGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        line_change |=> !line_change);                                         // R5
    AST_CHANGE_MOVES: assert property (@(posedge clk) disable iff (rst)
        line_change |-> line_state != $past(line_state));                      // R5
    AST_STATE_HELD: assert property (@(posedge clk) disable iff (rst)
        !line_change |-> line_state == $past(line_state));                     // R5
    AST_DWELL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        line_change |-> dwell == '0);                                          // R6
    AST_DWELL_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !line_change && $past(dwell) != DMAX)
            |-> dwell == DWELL_W'($past(dwell) + 1'b1));                       // R6
    AST_DWELL_SAT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !line_change && $past(dwell) == DMAX) |-> dwell == DMAX); // R6
    AST_RESET_SINGLE: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> !bus_reset);                                             // R8
    AST_RESET_HS_IDLE: assert property (@(posedge clk) disable iff (rst)
        bus_reset |-> ($past(line_state) == 2'b00 && $past(bus_mode) == 2'b00)); // R9

endmodule

bind usb_line_monitor lsm_checker #(.DWELL_W(DWELL_W)) u_lsm_checker (
    .clk         (clk),
    .rst         (rst),
    .bus_mode    (bus_mode),
    .line_state  (line_state),
    .line_change (line_change),
    .bus_reset   (bus_reset),
    .dwell       (dwell)
);

// File: tb/usb_line_monitor_bench.sv
module usb_line_monitor_bench;

    localparam int IDLE = 40;
    localparam int DW   = 6;
    localparam int DMAX = (1 << DW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    bus_mode = 2'b01;
    logic [1:0]    line_raw = 2'b01;
    logic [1:0]    line_state;
    logic          line_change;
    logic          bus_reset;
    logic [DW-1:0] dwell;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    usb_line_monitor #(.IDLE_CLKS(IDLE), .DWELL_W(DW)) u_usb_line_monitor (
        .clk         (clk),
        .rst         (rst),
        .bus_mode    (bus_mode),
        .line_raw    (line_raw),
        .line_state  (line_state),
        .line_change (line_change),
        .bus_reset   (bus_reset),
        .dwell       (dwell)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int expect_code(input int code, input int mode);
        if (mode == 2 && (code == 1 || code == 2)) return code ^ 3;
        return code;
    endfunction

    // Drive SE0 from a settled J and watch 50 cycles for the pulse.
    task automatic idle_run(input string req, input int fire_at);
        line_raw = 2'b00;
        for (int i = 1; i <= 50; i++) begin
            tick();
            check(req, bus_reset, (i == fire_at) ? 1 : 0);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int pulses;
        // R10 reset values
        tick(3);
        check("R10 state", line_state, 0);
        check("R10 change", line_change, 0);
        check("R10 reset", bus_reset, 0);
        check("R10 dwell", dwell, 0);
        rst = 1'b0;
        tick();
        check("R10 state after release", line_state, 0);
        check("R10 dwell after release", dwell, 1);
        tick(8);

        // R1 R2 R3 R5 R6 sweep over modes and transitions
        for (int m = 0; m < 4; m++) begin
            bus_mode = 2'(m);
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    if (a != b) begin
                        line_raw = 2'(a);
                        tick(6);
                        line_raw = 2'(b);
                        tick(3);
                        check("R1 old value held", line_state, expect_code(a, m));
                        check("R5 no early strobe", line_change, 0);
                        tick();
                        check((m == 2) ? "R3 decode" : "R2 decode", line_state, expect_code(b, m));
                        check("R5 strobe", line_change, 1);
                        check("R6 dwell zero", dwell, 0);
                        check("R9 no reset", bus_reset, 0);
                        tick();
                        check("R5 strobe ends", line_change, 0);
                        check("R6 dwell step", dwell, 1);
                    end
                end
            end
        end

        // R4 glitch rejection and two-cycle acceptance
        bus_mode = 2'b01;
        line_raw = 2'b01;
        tick(8);
        line_raw = 2'b10;
        tick();
        line_raw = 2'b01;
        pulses = 0;
        for (int i = 0; i < 8; i++) begin
            tick();
            pulses += line_change;
            check("R4 glitch ignored", line_state, 1);
        end
        check("R4 no strobe on glitch", pulses, 0);
        line_raw = 2'b10;
        tick();
        tick();
        line_raw = 2'b01;
        tick(2);
        check("R4 two-cycle accepted", line_state, 2);
        check("R4 two-cycle strobe", line_change, 1);
        tick(10);
        check("R4 back to J", line_state, 1);

        // R6 dwell counting and saturation
        line_raw = 2'b00;
        tick(8);
        line_raw = 2'b01;
        tick(4);
        check("R6 change seen", line_change, 1);
        tick(10);
        check("R6 dwell ten", dwell, 10);
        tick(80);
        check("R6 dwell saturated", dwell, DMAX);

        // R7 firing time, R8 single pulse and re-arm
        bus_mode = 2'b00;
        line_raw = 2'b01;
        tick(8);
        idle_run("R7 reset timing", IDLE + 4);
        pulses = 0;
        for (int i = 0; i < 100; i++) begin
            tick();
            pulses += bus_reset;
        end
        check("R8 one pulse per idle", pulses, 0);
        line_raw = 2'b01;
        tick(8);
        idle_run("R8 re-arm", IDLE + 4);

        // R9 abort before the limit restarts timing
        line_raw = 2'b01;
        tick(8);
        line_raw = 2'b00;
        pulses = 0;
        for (int i = 0; i < 30; i++) begin
            tick();
            pulses += bus_reset;
        end
        line_raw = 2'b01;
        for (int i = 0; i < 8; i++) begin
            tick();
            pulses += bus_reset;
        end
        check("R9 short idle silent", pulses, 0);
        idle_run("R9 restart timing", IDLE + 4);

        // R9 no reset outside high-speed device mode
        for (int m = 1; m < 3; m++) begin
            line_raw = 2'b01;
            bus_mode = 2'(m);
            tick(8);
            line_raw = 2'b00;
            pulses = 0;
            for (int i = 0; i < 120; i++) begin
                tick();
                pulses += bus_reset;
            end
            check("R9 mode gate", pulses, 0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule